// File: doc/BRIEF.md
# Lower-Half Write Guard and Acknowledge Policy

This block sits beside the serial-bus slave engine of a 256-byte nonvolatile store. It owns the protection state of the lower half of the array, addresses 00h to 7Fh. That state can be open, reversibly locked or permanently locked. For every byte phase of a transaction, the engine hands the block the decoded command byte fields, the phase, the word address, the write-protect pin and a flag that says whether a high voltage is on the A0 pin. The block answers on the same cycle with two flags. One says whether the slave should drive an acknowledge. The other says whether a write cycle may start.

Three protection commands carry device-type code 0110. Two of them, set-reversible and clear, are qualified by the high voltage on A0. The third, permanent-set, is qualified by the ordinary match against the address pins. The master can learn the current protection state only from the pattern of acknowledges it gets back. If a protection command is accepted in its data phase, the block holds it as pending. The block updates its state only when the engine reports that the following write cycle completed. An aborted cycle leaves the state as it was.

Top module: `lowhalf_guard`

## Requirements
- R1: After reset, prot_state reads 0 (open). The only encodings it ever takes are 0 (open), 1 (reversible) and 2 (permanent).
- R2: Decoding of the command byte works as follows. dev_type 1010 with dev_addr equal to pin_addr is a memory access. dev_type 0110 with a0_hv high is set-reversible when dev_addr is 001 and clear when dev_addr is 011. dev_type 0110 with a0_hv low and dev_addr equal to pin_addr is permanent-set. Any other combination gets no acknowledge in any phase.
- R3: In the permanent state, every protection command gets ack_en low and write_ok low in every phase. phase is encoded as 0 = command, 1 = word address, 2 = data.
- R4: In the reversible state, set-reversible gets no acknowledge in any phase. With wp_pin low, clear and permanent-set are acknowledged in all three phases and get write_ok in the data phase.
- R5: In the open or reversible state with wp_pin high, a protection command that is not refused is acknowledged in phases 0 and 1 only. It gets no acknowledge and no write_ok in phase 2, and no state change follows.
- R6: In the open state with wp_pin low, all three protection commands are acknowledged in every phase and get write_ok in phase 2.
- R7: While the lower half is locked (reversible or permanent), a memory write whose word_addr has bit 7 clear is acknowledged in phases 0 and 1 and gets neither ack_en nor write_ok in phase 2. Addresses with bit 7 set stay writable.
- R8: With wp_pin high, no memory write at any address gets write_ok or a phase-2 acknowledge. With wp_pin low in the open state, all 256 addresses are writable.
- R9: A protection command with rw_bit high gets no acknowledge on the command byte in the permanent state, and none in the reversible state when it is set-reversible. Otherwise the command byte is acknowledged. Phases 1 and 2 never are, and write_ok stays low.
- R10: prot_state changes only on a cycle_done pulse that follows an accepted protection data phase. An accepted set-reversible moves the state from open to reversible. An accepted clear moves it from reversible to open. An accepted permanent-set moves it to permanent. cycle_abort, or a new command byte, discards the pending change.
- R11: Once permanent, prot_state never leaves that state until reset.
- R12: The word address and data byte values of a protection command have no effect on the acknowledge, on write_ok or on the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| phase_vld | input | 1 | The current phase is a real byte phase, so its outcome may be latched |
| phase | input | 2 | Byte phase: 0 command, 1 word address, 2 data |
| dev_type | input | 4 | Device-type field of the command byte |
| dev_addr | input | 3 | Device-select field of the command byte |
| rw_bit | input | 1 | Read (1) or write (0) bit of the command byte |
| pin_addr | input | 3 | Logic levels strapped on the address pins |
| a0_hv | input | 1 | High voltage detected on A0 |
| word_addr | input | 8 | Target word address, or the don't-care byte of a protection command |
| wp_pin | input | 1 | Write-protect pin level |
| cycle_done | input | 1 | The write cycle has completed normally |
| cycle_abort | input | 1 | The write cycle was cancelled |
| ack_en | output | 1 | Drive an acknowledge for this phase |
| write_ok | output | 1 | A write cycle may run after this data phase |
| prot_state | output | 2 | 0 open, 1 reversible lock, 2 permanent lock |

## Verification
The embedded assertions are evaluated on every cycle. They cover the following invariants:
- the state encoding stays legal;
- the permanent state never leaves;
- the state never moves without cycle_done;
- wp_pin and rw_bit always suppress write_ok;
- every protection command is refused in the permanent state;
- write_ok always comes with an acknowledge in the data phase.

Other behaviour can only be shown by the bench's scenarios. This covers the full acknowledge pattern for each state, command and pin combination, and which transition each accepted command commits. It also covers discarding through abort, and the independence of the outcome from the don't-care bytes.

// File: rtl/lowhalf_guard.sv
module lowhalf_guard #(
  parameter int         AW        = 8,
  parameter logic [3:0] MEM_TYPE  = 4'b1010,
  parameter logic [3:0] PROT_TYPE = 4'b0110,
  parameter logic [2:0] SETR_SEL  = 3'b001,
  parameter logic [2:0] CLR_SEL   = 3'b011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_vld,
  input  logic [1:0]    phase,
  input  logic [3:0]    dev_type,
  input  logic [2:0]    dev_addr,
  input  logic          rw_bit,
  input  logic [2:0]    pin_addr,
  input  logic          a0_hv,
  input  logic [AW-1:0] word_addr,
  input  logic          wp_pin,
  input  logic          cycle_done,
  input  logic          cycle_abort,
  output logic          ack_en,
  output logic          write_ok,
  output logic [1:0]    prot_state
);
  localparam logic [1:0] PH_CMD = 2'd0, PH_ADR = 2'd1, PH_DAT = 2'd2;
  localparam logic [1:0] ST_OPEN = 2'd0, ST_REV = 2'd1, ST_PERM = 2'd2;
  localparam logic [1:0] K_NONE = 2'd0, K_SETR = 2'd1, K_CLR = 2'd2, K_PERM = 2'd3;

  logic [1:0] kind, pend;
  logic       is_mem, refused, locked_low;

  assign is_mem     = (dev_type == MEM_TYPE) && (dev_addr == pin_addr);
  assign locked_low = (prot_state != ST_OPEN) && !word_addr[AW-1];
  assign refused    = (prot_state == ST_PERM) ||
                      (prot_state == ST_REV && kind == K_SETR);

  always_comb begin
    kind = K_NONE;
    if (dev_type == PROT_TYPE) begin
      if (a0_hv) begin
        if (dev_addr == SETR_SEL)     kind = K_SETR;
        else if (dev_addr == CLR_SEL) kind = K_CLR;
      end else if (dev_addr == pin_addr) begin
        kind = K_PERM;
      end
    end
  end

  always_comb begin
    ack_en   = 1'b0;
    write_ok = 1'b0;
    if (is_mem) begin
      if (rw_bit) ack_en = (phase == PH_CMD);
      else if (phase == PH_CMD || phase == PH_ADR) ack_en = 1'b1;
      else if (phase == PH_DAT) begin
        write_ok = !wp_pin && !locked_low;
        ack_en   = write_ok;
      end
    end else if (kind != K_NONE && !refused) begin
      if (rw_bit) ack_en = (phase == PH_CMD);
      else if (phase == PH_CMD || phase == PH_ADR) ack_en = 1'b1;
      else if (phase == PH_DAT) begin
        write_ok = !wp_pin;
        ack_en   = write_ok;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_state <= ST_OPEN;
      pend       <= K_NONE;
    end else begin
      if (cycle_done || cycle_abort || (phase_vld && phase == PH_CMD))
        pend <= K_NONE;
      else if (phase_vld && phase == PH_DAT && write_ok && kind != K_NONE)
        pend <= kind;
      if (cycle_done && !cycle_abort && prot_state != ST_PERM) begin
        case (pend)
          K_SETR:  if (prot_state == ST_OPEN) prot_state <= ST_REV;
          K_CLR:   if (prot_state == ST_REV)  prot_state <= ST_OPEN;
          K_PERM:  prot_state <= ST_PERM;
          default: ;
        endcase
      end
    end
  end

  // R1
  state_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(prot_state));
  // R11
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_state == ST_PERM |=> prot_state == ST_PERM);
  // R10
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_done |=> $stable(prot_state));
  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_pin |-> !write_ok);
  // R9
  read_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rw_bit |-> !write_ok);
  // R3
  perm_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_state == ST_PERM && kind != K_NONE) |-> !ack_en);
  // R6
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_ok |-> (ack_en && phase == PH_DAT));
endmodule

// File: tb/tb_lowhalf_guard.sv
`timescale 1ns/1ps
module tb_lowhalf_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic phase_vld = 1'b0, rw_bit = 1'b0, a0_hv = 1'b0, wp_pin = 1'b0;
  logic cycle_done = 1'b0, cycle_abort = 1'b0;
  logic [1:0] phase = 2'd0;
  logic [3:0] dev_type = 4'h0;
  logic [2:0] dev_addr = 3'd0;
  logic [2:0] pin_addr = 3'd5;
  logic [7:0] word_addr = 8'h00;
  logic ack_en, write_ok;
  logic [1:0] prot_state;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  lowhalf_guard dut (.clk(clk), .rst_n(rst_n), .phase_vld(phase_vld), .phase(phase),
    .dev_type(dev_type), .dev_addr(dev_addr), .rw_bit(rw_bit), .pin_addr(pin_addr),
    .a0_hv(a0_hv), .word_addr(word_addr), .wp_pin(wp_pin), .cycle_done(cycle_done),
    .cycle_abort(cycle_abort), .ack_en(ack_en), .write_ok(write_ok), .prot_state(prot_state));

  // {req[27:24], st[23:22], type[21:18], sel[17:15], rw, hv, wp, addr[11:4], ph[3:2], ack, wr}
  localparam int NV = 32;
  localparam logic [27:0] VEC [NV] = '{
    {4'd8, 2'd0,4'hA,3'd5,1'b0,1'b0,1'b0,8'h10,2'd0,1'b1,1'b0}, // R8
    {4'd8, 2'd0,4'hA,3'd5,1'b0,1'b0,1'b0,8'h10,2'd2,1'b1,1'b1}, // R8
    {4'd8, 2'd0,4'hA,3'd5,1'b0,1'b0,1'b1,8'h90,2'd2,1'b0,1'b0}, // R8
    {4'd8, 2'd0,4'hA,3'd5,1'b0,1'b0,1'b1,8'h10,2'd2,1'b0,1'b0}, // R8
    {4'd6, 2'd0,4'h6,3'd1,1'b0,1'b1,1'b0,8'h33,2'd0,1'b1,1'b0}, // R6
    {4'd6, 2'd0,4'h6,3'd1,1'b0,1'b1,1'b0,8'h33,2'd2,1'b1,1'b1}, // R6
    {4'd6, 2'd0,4'h6,3'd3,1'b0,1'b1,1'b0,8'h33,2'd2,1'b1,1'b1}, // R6
    {4'd6, 2'd0,4'h6,3'd5,1'b0,1'b0,1'b0,8'h33,2'd2,1'b1,1'b1}, // R6
    {4'd5, 2'd0,4'h6,3'd5,1'b0,1'b0,1'b1,8'h33,2'd1,1'b1,1'b0}, // R5
    {4'd5, 2'd0,4'h6,3'd5,1'b0,1'b0,1'b1,8'h33,2'd2,1'b0,1'b0}, // R5
    {4'd9, 2'd0,4'h6,3'd1,1'b1,1'b1,1'b0,8'h33,2'd0,1'b1,1'b0}, // R9
    {4'd9, 2'd0,4'h6,3'd1,1'b1,1'b1,1'b0,8'h33,2'd1,1'b0,1'b0}, // R9
    {4'd2, 2'd0,4'h6,3'd2,1'b0,1'b1,1'b0,8'h33,2'd0,1'b0,1'b0}, // R2
    {4'd2, 2'd0,4'hA,3'd4,1'b0,1'b0,1'b0,8'h33,2'd0,1'b0,1'b0}, // R2
    {4'd2, 2'd0,4'hA,3'd5,1'b1,1'b0,1'b0,8'h33,2'd0,1'b1,1'b0}, // R2
    {4'd7, 2'd1,4'hA,3'd5,1'b0,1'b0,1'b0,8'h10,2'd2,1'b0,1'b0}, // R7
    {4'd7, 2'd1,4'hA,3'd5,1'b0,1'b0,1'b0,8'h10,2'd1,1'b1,1'b0}, // R7
    {4'd7, 2'd1,4'hA,3'd5,1'b0,1'b0,1'b0,8'h80,2'd2,1'b1,1'b1}, // R7
    {4'd4, 2'd1,4'h6,3'd1,1'b0,1'b1,1'b0,8'h33,2'd0,1'b0,1'b0}, // R4
    {4'd4, 2'd1,4'h6,3'd1,1'b0,1'b1,1'b0,8'h33,2'd2,1'b0,1'b0}, // R4
    {4'd4, 2'd1,4'h6,3'd3,1'b0,1'b1,1'b0,8'h33,2'd2,1'b1,1'b1}, // R4
    {4'd4, 2'd1,4'h6,3'd5,1'b0,1'b0,1'b0,8'h33,2'd2,1'b1,1'b1}, // R4
    {4'd5, 2'd1,4'h6,3'd3,1'b0,1'b1,1'b1,8'h33,2'd2,1'b0,1'b0}, // R5
    {4'd5, 2'd1,4'h6,3'd3,1'b0,1'b1,1'b1,8'h33,2'd1,1'b1,1'b0}, // R5
    {4'd9, 2'd1,4'h6,3'd1,1'b1,1'b1,1'b0,8'h33,2'd0,1'b0,1'b0}, // R9
    {4'd9, 2'd1,4'h6,3'd3,1'b1,1'b1,1'b0,8'h33,2'd0,1'b1,1'b0}, // R9
    {4'd3, 2'd2,4'h6,3'd1,1'b0,1'b1,1'b0,8'h33,2'd0,1'b0,1'b0}, // R3
    {4'd3, 2'd2,4'h6,3'd3,1'b0,1'b1,1'b0,8'h33,2'd1,1'b0,1'b0}, // R3
    {4'd3, 2'd2,4'h6,3'd5,1'b0,1'b0,1'b0,8'h33,2'd2,1'b0,1'b0}, // R3
    {4'd7, 2'd2,4'hA,3'd5,1'b0,1'b0,1'b0,8'h7F,2'd2,1'b0,1'b0}, // R7
    {4'd7, 2'd2,4'hA,3'd5,1'b0,1'b0,1'b0,8'hFF,2'd2,1'b1,1'b1}, // R7
    {4'd9, 2'd2,4'h6,3'd5,1'b1,1'b0,1'b0,8'h33,2'd0,1'b0,1'b0}  // R9
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [3:0] t, input logic [2:0] s, input logic hv,
                         input logic wp, input logic [7:0] dbyte, input bit abort);
    for (int ph = 0; ph < 3; ph++) begin
      @(negedge clk);
      dev_type = t; dev_addr = s; a0_hv = hv; wp_pin = wp; rw_bit = 1'b0;
      word_addr = dbyte; phase = ph[1:0]; phase_vld = 1'b1;
    end
    @(negedge clk);
    phase_vld = 1'b0;
    if (abort) cycle_abort = 1'b1; else cycle_done = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0; cycle_abort = 1'b0; wp_pin = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [1:0] cur;
    do_reset();
    chk("R1 reset state", {6'd0, prot_state}, 8'd0);
    cur = 2'd0;
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      if (v[23:22] != cur) begin
        if (v[23:22] == 2'd1) run_cmd(4'h6, 3'd1, 1'b1, 1'b0, 8'h00, 0);
        else                  run_cmd(4'h6, 3'd5, 1'b0, 1'b0, 8'h00, 0);
        cur = v[23:22];
        chk("R10 commit into next state", {6'd0, prot_state}, {6'd0, cur});
      end
      @(negedge clk);
      dev_type = v[21:18]; dev_addr = v[17:15]; rw_bit = v[14]; a0_hv = v[13];
      wp_pin = v[12]; word_addr = v[11:4]; phase = v[3:2];
      #1;
      chk($sformatf("R%0d vector %0d ack/wr", v[27:24], i), {6'd0, ack_en, write_ok}, {6'd0, v[1:0]});
    end
    wp_pin = 1'b0; rw_bit = 1'b0;

    do_reset();
    chk("R1 state after second reset", {6'd0, prot_state}, 8'd0);
    run_cmd(4'h6, 3'd1, 1'b1, 1'b0, 8'h00, 1);
    chk("R10 aborted set keeps open", {6'd0, prot_state}, 8'd0);
    @(negedge clk); cycle_done = 1'b1;
    @(negedge clk); cycle_done = 1'b0; #1;
    chk("R10 bare cycle_done keeps open", {6'd0, prot_state}, 8'd0);
    run_cmd(4'h6, 3'd1, 1'b1, 1'b1, 8'h00, 0);
    chk("R5 wp-high set leaves open", {6'd0, prot_state}, 8'd0);

    @(negedge clk);
    dev_type = 4'h6; dev_addr = 3'd1; a0_hv = 1'b1; rw_bit = 1'b0; wp_pin = 1'b0; phase = 2'd2;
    word_addr = 8'h00; #1;
    chk("R12 data 00 ack/wr", {6'd0, ack_en, write_ok}, 8'd3);
    word_addr = 8'hFF; #1;
    chk("R12 data FF ack/wr", {6'd0, ack_en, write_ok}, 8'd3);

    run_cmd(4'h6, 3'd1, 1'b1, 1'b0, 8'hA5, 0);
    chk("R10 set commits reversible", {6'd0, prot_state}, 8'd1);
    run_cmd(4'h6, 3'd3, 1'b1, 1'b0, 8'h5A, 0);
    chk("R12 clear with odd data returns open", {6'd0, prot_state}, 8'd0);
    run_cmd(4'h6, 3'd5, 1'b0, 1'b0, 8'hC3, 0);
    chk("R10 permanent from open", {6'd0, prot_state}, 8'd2);
    run_cmd(4'h6, 3'd3, 1'b1, 1'b0, 8'h00, 0);
    chk("R11 clear cannot lift permanent", {6'd0, prot_state}, 8'd2);
    run_cmd(4'h6, 3'd1, 1'b1, 1'b0, 8'h00, 0);
    chk("R11 set keeps permanent", {6'd0, prot_state}, 8'd2);

    finish_run();
  end
endmodule